// File: doc/BRIEF.md
# Adaptive Transmit Pacing Controller

This block decides how long a transmit MAC waits before the first attempt at each new frame. It remembers recent contention on the medium in a small saturating history counter. Any frame that ends after a deferral or a collision of any kind sets the counter to its full-scale value. Each frame that goes out clean lowers it by one, and it never goes below zero.

When pacing is enabled, the counter is non-zero, and the MAC requests the first attempt of a frame, the block tells the gap timer to use an extended gap of several inter-packet gap periods. In every other case it asks for a single normal gap. Retransmissions after a collision are never paced, because the backoff logic outside this block handles them.

The counter keeps tracking frame outcomes while pacing is disabled. Its state is therefore current at the moment pacing is turned back on. The gap decision is registered, so it is valid one clock after the request is sampled.

Top module: `tx_pace_ctrl`

## Requirements
- R1: After reset the history counter is zero, `ext_gap_o` is 0 and `gap_mult_o` is 1.
- R2: A cycle in which any of `defer_i`, `col_single_i`, `col_multi_i` or `col_excess_i` is high loads the counter with 31, whatever its previous value.
- R3: A cycle in which only `tx_ok_i` is high among the five outcome inputs lowers the counter by one. At zero the counter stays at zero.
- R4: When `tx_ok_i` is high in the same cycle as one or more contention inputs, the load to 31 takes priority and no decrement happens.
- R5: In a cycle with all five outcome inputs low, the counter keeps its value.
- R6: With `pace_en_i` low the outputs always request the normal gap (`ext_gap_o`=0, `gap_mult_o`=1). The counter still updates on outcome strobes.
- R7: With `pace_en_i` high, `frame_req_i` high, `retry_i` low and the counter at zero, the next cycle shows `ext_gap_o`=0 and `gap_mult_o`=1.
- R8: With `pace_en_i` high, `frame_req_i` high, `retry_i` low and the counter non-zero, the next cycle shows `ext_gap_o`=1 and `gap_mult_o`=4.
- R9: When `retry_i` is high, or `frame_req_i` is low, the next cycle requests the normal gap regardless of the counter.
- R10: The gap outputs are registered from inputs sampled at the previous rising edge. An outcome strobe in the same cycle as a request does not change the decision for that request: the decision uses the counter value from before the update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pace_en_i | input | 1 | Pacing enable |
| defer_i | input | 1 | Frame completed after a deferral |
| col_single_i | input | 1 | Frame completed after one collision |
| col_multi_i | input | 1 | Frame completed after several collisions |
| col_excess_i | input | 1 | Frame abandoned after excessive collisions |
| tx_ok_i | input | 1 | Frame completed without contention |
| frame_req_i | input | 1 | A frame is waiting for its next attempt |
| retry_i | input | 1 | The pending attempt is a retransmission |
| ext_gap_o | output | 1 | 1 requests the extended gap |
| gap_mult_o | output | 3 | Gap length in IPG periods (1 or 4) |

## Verification
The bench walks the counter down from 31 after each kind of contention event. It probes the gap decision after every clean frame, so a counter that wraps below zero, decrements by more than one, or loads the wrong value shows up as an extended gap at the wrong frame count. All 32 combinations of the five outcome inputs are applied. A design that lets the success strobe beat a collision flag, or that drifts with no strobe present, then mispredicts the next probe. The bench also checks the following cases:
- Retransmission requests and disabled pacing must give the normal gap while the counter is full. A design that paces retries would show a wrong gap here.
- The counter must keep its history while pacing is off. A design that freezes it would report a stale extended gap.
- A clean strobe that coincides with a request while the counter is at one must still produce an extended gap. A design that uses the post-update count would release that frame early.

// File: rtl/tx_pace_pkg.sv
package tx_pace_pkg;

  typedef struct packed {
    logic defer;
    logic col_one;
    logic col_many;
    logic col_excess;
    logic clean;
  } pace_evt_t;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_LOAD = 2'd1,
    UPD_STEP = 2'd2
  } pace_upd_e;

endpackage

// File: rtl/tx_pace_evt_dec.sv
module tx_pace_evt_dec
  import tx_pace_pkg::*;
(
  input  pace_evt_t evt_i,
  output pace_upd_e upd_o
);

  logic contention;

  assign contention = evt_i.defer | evt_i.col_one | evt_i.col_many | evt_i.col_excess;

  // contention wins over a simultaneous clean strobe
  always_comb begin
    if (contention)      upd_o = UPD_LOAD;
    else if (evt_i.clean) upd_o = UPD_STEP;
    else                 upd_o = UPD_HOLD;
  end

endmodule

// File: rtl/tx_pace_hist_cnt.sv
module tx_pace_hist_cnt
  import tx_pace_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pace_upd_e        upd_i,
  output logic             busy_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (upd_i)
        UPD_LOAD: cnt_q <= CNT_MAX;
        UPD_STEP: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign busy_o = (cnt_q != '0);

  // R2
  load_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i == UPD_LOAD) |=> (cnt_q == CNT_MAX));

  // R3
  step_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i == UPD_STEP && cnt_q == '0) |=> (cnt_q == '0));

  // R5
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i == UPD_HOLD) |=> $stable(cnt_q));

endmodule

// File: rtl/tx_pace_gap_sel.sv
module tx_pace_gap_sel #(
  parameter int unsigned NORM_MULT = 1,
  parameter int unsigned EXT_MULT  = 4,
  parameter int unsigned MULT_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pace_en_i,
  input  logic              busy_i,
  input  logic              frame_req_i,
  input  logic              retry_i,
  output logic              ext_gap_o,
  output logic [MULT_W-1:0] gap_mult_o
);

  localparam logic [MULT_W-1:0] NORM_V = MULT_W'(NORM_MULT);
  localparam logic [MULT_W-1:0] EXT_V  = MULT_W'(EXT_MULT);

  logic ext_d, ext_q;

  // only the first attempt of a frame is paced
  assign ext_d = pace_en_i & busy_i & frame_req_i & ~retry_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 1'b0;
    else         ext_q <= ext_d;
  end

  assign ext_gap_o  = ext_q;
  assign gap_mult_o = ext_q ? EXT_V : NORM_V;

  // R6
  no_pace_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pace_en_i |=> (!ext_gap_o && gap_mult_o == NORM_V));

  // R9
  retry_unpaced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_i || !frame_req_i) |=> (gap_mult_o == NORM_V));

  // R8
  paced_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pace_en_i && busy_i && frame_req_i && !retry_i) |=> (ext_gap_o && gap_mult_o == EXT_V));

  // R7
  idle_hist_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i) |=> !ext_gap_o);

endmodule

// File: rtl/tx_pace_ctrl.sv
module tx_pace_ctrl
  import tx_pace_pkg::*;
#(
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned NORM_MULT = 1,
  parameter int unsigned EXT_MULT  = 4,
  localparam int unsigned MULT_W   = $clog2(EXT_MULT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pace_en_i,
  input  logic              defer_i,
  input  logic              col_single_i,
  input  logic              col_multi_i,
  input  logic              col_excess_i,
  input  logic              tx_ok_i,
  input  logic              frame_req_i,
  input  logic              retry_i,
  output logic              ext_gap_o,
  output logic [MULT_W-1:0] gap_mult_o
);

  pace_evt_t evt;
  pace_upd_e upd;
  logic      busy;

  assign evt = '{defer: defer_i, col_one: col_single_i, col_many: col_multi_i,
                 col_excess: col_excess_i, clean: tx_ok_i};

  tx_pace_evt_dec u_dec (
    .evt_i (evt),
    .upd_o (upd)
  );

  tx_pace_hist_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd),
    .busy_o (busy)
  );

  tx_pace_gap_sel #(
    .NORM_MULT (NORM_MULT),
    .EXT_MULT  (EXT_MULT),
    .MULT_W    (MULT_W)
  ) u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pace_en_i   (pace_en_i),
    .busy_i      (busy),
    .frame_req_i (frame_req_i),
    .retry_i     (retry_i),
    .ext_gap_o   (ext_gap_o),
    .gap_mult_o  (gap_mult_o)
  );

  // R4
  load_beats_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((defer_i || col_single_i || col_multi_i || col_excess_i) && tx_ok_i) |-> (upd == UPD_LOAD));

endmodule

// File: tb/tx_pace_ctrl_bench.sv
`timescale 1ns/1ps
module tx_pace_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pace_en = 1'b0, defer = 1'b0, col1 = 1'b0, colm = 1'b0, colx = 1'b0, ok = 1'b0;
  logic req = 1'b0, retry = 1'b0;
  logic ext;
  logic [2:0] mult;

  int total = 0;
  int bad = 0;
  int model = 0;

  always #10 clk = ~clk;

  tx_pace_ctrl u_tx_pace_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pace_en_i(pace_en),
    .defer_i(defer), .col_single_i(col1), .col_multi_i(colm), .col_excess_i(colx),
    .tx_ok_i(ok), .frame_req_i(req), .retry_i(retry),
    .ext_gap_o(ext), .gap_mult_o(mult)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bits: [4]=defer [3]=col_single [2]=col_multi [1]=col_excess [0]=tx_ok
  task automatic strobe(input logic [4:0] p);
    @(negedge clk);
    {defer, col1, colm, colx, ok} = p;
    @(negedge clk);
    {defer, col1, colm, colx, ok} = '0;
    if (p[4:1] != 0) model = 31;
    else if (p[0] && model > 0) model = model - 1;
  endtask

  task automatic probe(input string tag, input logic en, input logic rt);
    int exp_ext;
    @(negedge clk);
    pace_en = en; req = 1'b1; retry = rt;
    @(negedge clk);
    exp_ext = (en && !rt && model != 0) ? 1 : 0;
    chk({tag, " ext"}, int'(ext), exp_ext);
    chk({tag, " mult"}, int'(mult), exp_ext ? 4 : 1);
    req = 1'b0; retry = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ext", int'(ext), 0);
    chk("R1 mult", int'(mult), 1);
    rst_n = 1'b1;
    probe("R1 R7 first request", 1'b1, 1'b0);

    // R2 R3 R8 R7: each contention kind, then walk down to zero and below
    for (int k = 1; k <= 4; k++) begin
      strobe(5'b1 << k);
      probe("R2 after load", 1'b1, 1'b0);
      for (int n = 0; n < 33; n++) begin
        strobe(5'b00001);
        probe("R3 R8 R7 walk", 1'b1, 1'b0);
      end
    end

    // R4 R5: every outcome combination, probing after each
    strobe(5'b01000);
    for (int n = 0; n < 29; n++) strobe(5'b00001);
    for (int p = 0; p < 32; p++) begin
      strobe(p[4:0]);
      probe("R4 R5 combo", 1'b1, 1'b0);
      strobe(5'b00001);
      probe("R4 R5 combo step", 1'b1, 1'b0);
    end

    // R5 idle cycles with counter at one
    strobe(5'b00010);
    for (int n = 0; n < 30; n++) strobe(5'b00001);
    repeat (20) @(negedge clk);
    probe("R5 idle hold", 1'b1, 1'b0);

    // R9 retry and no request
    strobe(5'b10000);
    probe("R9 retry", 1'b1, 1'b1);
    @(negedge clk);
    pace_en = 1'b1; req = 1'b0;
    @(negedge clk);
    chk("R9 no request", int'(ext), 0);

    // R6 disabled pacing but counter keeps moving
    probe("R6 off full", 1'b0, 1'b0);
    for (int n = 0; n < 31; n++) strobe(5'b00001);
    probe("R6 off drained", 1'b0, 1'b0);
    probe("R6 re-enabled drained", 1'b1, 1'b0);
    strobe(5'b00100);
    probe("R6 re-enabled loaded", 1'b1, 1'b0);

    // R10 same-cycle strobe uses pre-update count (model at 1)
    for (int n = 0; n < 30; n++) strobe(5'b00001);
    @(negedge clk);
    pace_en = 1'b1; req = 1'b1; ok = 1'b1;
    @(negedge clk);
    ok = 1'b0; req = 1'b0;
    chk("R10 pre-update decision", int'(ext), 1);
    model = 0;
    probe("R10 after update", 1'b1, 1'b0);
    // R10 same-cycle load with zero count still gives normal gap
    @(negedge clk);
    req = 1'b1; colx = 1'b1;
    @(negedge clk);
    colx = 1'b0; req = 1'b0;
    chk("R10 load same cycle", int'(ext), 0);
    model = 31;
    probe("R10 load visible", 1'b1, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule